// File: doc/BRIEF.md
# Shared Memory Window Isolation Controller

This block sits between a host processor's memory bus and the local memories of a set of slave processors. Each slave's 64 KB local memory is also visible to the host as a window. Host and slave use the same physical address for each location, so no relocation is needed. The controller decodes the host address into one window per slave and gates the isolating data buffers between the two buses. It sets the buffer direction from the host read and write strobes. It also drives each slave's active-low reset from a host-written control bit.

Each slave reports its bus cycle type on a 3-bit status code. The halt code is 3'b011. When a slave enters halt, the controller latches an interrupt request for the host. The host then reads the results from the top 4 KB of the window, loads the next job into the lower 60 KB, and restarts the slave by releasing its reset. The buffers never turn on while the slave may be driving its own memory, which means it must be either held in reset or halted.

Top module: `bus_window_ctrl`

## Requirements
- R1: Window i decodes host addresses 0xD0000 + i*0x10000 through 0xDFFFF + i*0x10000; at most one window is hit, and an address outside every window enables no buffer.
- R2: `res_hit[i]` is high exactly when the host address is in window i at offset 0xF000 or above (the 4 KB result area); offsets below 0xF000 are the program area.
- R3: `buf_en[i]` is high only when window i is hit, exactly one of `host_rd`/`host_wr` is high, and the grant bit of slave i is set; with no strobe, both strobes, or no grant it is low.
- R4: `buf_dir[i]` is 1 while buffer i is enabled for a host write, and 0 for a host read and whenever the buffer is disabled.
- R5: Host access to window i is refused (buffer off) while slave i runs and is not halted; it is allowed once slave i is held in reset or its sampled status is halt.
- R6: A control write (`ctl_we`) loads, per slave i, bit 3i as the grant bit and bit 3i+1 as the run bit; `slv_reset_n[i]` equals the run bit from the cycle after the write.
- R7: Status 3'b011 means halt. `host_irq[i]` is set at the first clock edge where the status of slave i is 3'b011 and the previously sampled status was not halt (sampled state is not-halt after reset). A halt status that is held constant does not set the request again.
- R8: `host_irq[i]` stays set until a control write with bit 3i+2 high, or a control write that takes the run bit of slave i from 0 to 1; writes that do neither leave it set. A new halt edge wins over a clear in the same cycle.
- R9: After reset every slave is held in reset, no grant is set, no buffer is enabled and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 20 | Host physical memory address |
| host_rd | input | 1 | Host memory read strobe, active high |
| host_wr | input | 1 | Host memory write strobe, active high |
| ctl_we | input | 1 | Control port write strobe |
| ctl_wdata | input | 6 | Control data, 3 bits per slave: grant, run, interrupt clear |
| slv_status | input | 6 | Bus status code per slave, 3 bits each |
| buf_en | output | 2 | Isolation buffer enable per window |
| buf_dir | output | 2 | Buffer direction per window, 1 = host to memory |
| res_hit | output | 2 | Host address lies in the result area of the window |
| slv_reset_n | output | 2 | Active-low reset per slave |
| host_irq | output | 2 | Latched halt interrupt per slave |

## Verification
On every cycle, the assertions check the safety rules. An enabled buffer always has its grant and a hit window, and its slave is either in reset or halted. The direction matches the write strobe and is low when the buffer is idle. No two windows hit at once. A halt edge always leaves a pending interrupt. Other behaviour needs the directed scenarios to show it: the exact address bounds of each window and of its result area, the cycle in which a control write reaches the reset line, that a held halt does not re-raise the request after a clear, and which control writes clear a request and which leave it set.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  // per-slave control field layout inside the control word
  localparam int CTL_BITS  = 3;
  localparam int CTL_GRANT = 0;
  localparam int CTL_RUN   = 1;
  localparam int CTL_CLR   = 2;
  localparam int STAT_W    = 3;
  localparam logic [STAT_W-1:0] ST_HALT = 3'b011;
endpackage

// File: rtl/bwc_rst_sync.sv
module bwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/bwc_win_decode.sv
module bwc_win_decode #(
  parameter int ADDR_W     = 20,
  parameter int WIN_AW     = 16,
  parameter int RES_AW     = 12,
  parameter int NUM_SLV    = 2,
  parameter int FIRST_PAGE = 13
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_SLV-1:0] win_hit,
  output logic [NUM_SLV-1:0] res_hit
);
  localparam int PAGE_W = ADDR_W - WIN_AW;
  localparam logic [WIN_AW-1:0] RES_BASE = WIN_AW'((1 << WIN_AW) - (1 << RES_AW));

  logic [PAGE_W-1:0] page;
  logic [WIN_AW-1:0] offs;
  logic              in_res;

  assign page   = addr[ADDR_W-1:WIN_AW];
  assign offs   = addr[WIN_AW-1:0];
  assign in_res = (offs >= RES_BASE);

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_win
    localparam logic [PAGE_W-1:0] MY_PAGE = PAGE_W'(FIRST_PAGE + i);
    assign win_hit[i] = (page == MY_PAGE);
    assign res_hit[i] = win_hit[i] & in_res;
  end
endmodule

// File: rtl/bwc_slave_ctl.sv
module bwc_slave_ctl
  import bwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              grant_wr,
  input  logic              run_wr,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] status,
  output logic              grant,
  output logic              run,
  output logic              halted,
  output logic              irq
);
  logic grant_q, grant_d;
  logic run_q, run_d;
  logic halt_q, halt_d;
  logic irq_q, irq_d;
  logic halt_now, halt_edge, release_ev, clr_ev;

  always_comb begin
    halt_now   = (status == ST_HALT);
    halt_edge  = halt_now & ~halt_q;
    release_ev = ctl_we & run_wr & ~run_q;
    clr_ev     = (ctl_we & clr_wr) | release_ev;
    grant_d    = ctl_we ? grant_wr : grant_q;
    run_d      = ctl_we ? run_wr   : run_q;
    halt_d     = halt_now;
    irq_d      = halt_edge | (irq_q & ~clr_ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      run_q   <= 1'b0;
      halt_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      run_q   <= run_d;
      halt_q  <= halt_d;
      irq_q   <= irq_d;
    end
  end

  assign grant  = grant_q;
  assign run    = run_q;
  assign halted = halt_q;
  assign irq    = irq_q;

  AST_IRQ_ON_HALT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_HALT) && !halted |=> irq); // R7
  AST_IRQ_RISE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> halted); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ctl_we |=> irq); // R8
  AST_RUN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> run == $past(run_wr)); // R6
endmodule

// File: rtl/bwc_buf_gate.sv
module bwc_buf_gate #(
  parameter int NUM_SLV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SLV-1:0] win_hit,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [NUM_SLV-1:0] grant,
  input  logic [NUM_SLV-1:0] run,
  input  logic [NUM_SLV-1:0] halted,
  output logic [NUM_SLV-1:0] buf_en,
  output logic [NUM_SLV-1:0] buf_dir
);
  logic one_strobe;
  assign one_strobe = host_rd ^ host_wr;

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_gate
    logic quiet;
    assign quiet      = ~run[i] | halted[i];
    assign buf_en[i]  = win_hit[i] & one_strobe & grant[i] & quiet;
    assign buf_dir[i] = buf_en[i] & host_wr;

    AST_EN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en[i] |-> grant[i] && win_hit[i] && (host_rd != host_wr)); // R3
    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en[i] |-> (!run[i] || halted[i])); // R5
    AST_DIR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      buf_en[i] && host_wr |-> buf_dir[i]); // R4
    AST_DIR_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_en[i] |-> !buf_dir[i]); // R4
  end
endmodule

// File: rtl/bus_window_ctrl.sv
module bus_window_ctrl
  import bwc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WIN_AW     = 16,
  parameter int RES_AW     = 12,
  parameter int NUM_SLV    = 2,
  parameter int FIRST_PAGE = 13,
  localparam int CTL_W     = CTL_BITS * NUM_SLV,
  localparam int ST_W      = STAT_W * NUM_SLV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic [ST_W-1:0]    slv_status,
  output logic [NUM_SLV-1:0] buf_en,
  output logic [NUM_SLV-1:0] buf_dir,
  output logic [NUM_SLV-1:0] res_hit,
  output logic [NUM_SLV-1:0] slv_reset_n,
  output logic [NUM_SLV-1:0] host_irq
);
  logic               rst_i_n;
  logic [NUM_SLV-1:0] win_hit;
  logic [NUM_SLV-1:0] grant, run, halted;

  bwc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  bwc_win_decode #(
    .ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .RES_AW(RES_AW),
    .NUM_SLV(NUM_SLV), .FIRST_PAGE(FIRST_PAGE)
  ) u_dec (
    .addr(host_addr), .win_hit(win_hit), .res_hit(res_hit)
  );

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
    bwc_slave_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .ctl_we   (ctl_we),
      .grant_wr (ctl_wdata[CTL_BITS*i + CTL_GRANT]),
      .run_wr   (ctl_wdata[CTL_BITS*i + CTL_RUN]),
      .clr_wr   (ctl_wdata[CTL_BITS*i + CTL_CLR]),
      .status   (slv_status[STAT_W*i +: STAT_W]),
      .grant    (grant[i]),
      .run      (run[i]),
      .halted   (halted[i]),
      .irq      (host_irq[i])
    );
    assign slv_reset_n[i] = run[i];
  end

  bwc_buf_gate #(.NUM_SLV(NUM_SLV)) u_gate (
    .clk(clk), .rst_n(rst_i_n), .win_hit(win_hit),
    .host_rd(host_rd), .host_wr(host_wr),
    .grant(grant), .run(run), .halted(halted),
    .buf_en(buf_en), .buf_dir(buf_dir)
  );

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(win_hit)); // R1
  AST_RESULT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones(res_hit & ~win_hit) == 0); // R2
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_i_n |=> (host_irq == '0) && (slv_reset_n == '0)); // R9
endmodule

// File: tb/bus_window_ctrl_tb.sv
`timescale 1ns/1ps
module bus_window_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] host_addr;
  logic        host_rd, host_wr, ctl_we;
  logic [5:0]  ctl_wdata, slv_status;
  logic [1:0]  buf_en, buf_dir, res_hit, slv_reset_n, host_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  bus_window_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .slv_status(slv_status), .buf_en(buf_en), .buf_dir(buf_dir),
    .res_hit(res_hit), .slv_reset_n(slv_reset_n), .host_irq(host_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [5:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic bus(input logic [19:0] a, input logic rd, input logic wr);
    host_addr = a; host_rd = rd; host_wr = wr;
    #1;
  endtask

  task automatic t_reset;
    chk("R9", "buf_en after reset", buf_en, 2'b00);
    chk("R9", "slv_reset_n after reset", slv_reset_n, 2'b00);
    chk("R9", "host_irq after reset", host_irq, 2'b00);
    bus(20'hD0000, 1, 0);
    chk("R9", "no grant after reset", buf_en, 2'b00);
  endtask

  task automatic t_decode;
    ctl_write(6'b001_001);               // grant both, both held in reset
    bus(20'hD0000, 1, 0); chk("R1", "D0000", buf_en, 2'b01);
    bus(20'hDFFFF, 1, 0); chk("R1", "DFFFF", buf_en, 2'b01);
    bus(20'hE0000, 1, 0); chk("R1", "E0000", buf_en, 2'b10);
    bus(20'hEFFFF, 1, 0); chk("R1", "EFFFF", buf_en, 2'b10);
    bus(20'hCFFFF, 1, 0); chk("R1", "CFFFF below", buf_en, 2'b00);
    bus(20'hF0000, 1, 0); chk("R1", "F0000 above", buf_en, 2'b00);
  endtask

  task automatic t_gate;
    bus(20'hD1234, 0, 0); chk("R3", "no strobe", buf_en, 2'b00);
    bus(20'hD1234, 1, 1); chk("R3", "both strobes", buf_en, 2'b00);
    ctl_write(6'b001_000);               // grant slave1 only
    bus(20'hD1234, 1, 0); chk("R3", "no grant slave0", buf_en, 2'b00);
    bus(20'hE1234, 0, 1); chk("R3", "grant slave1", buf_en, 2'b10);
    ctl_write(6'b001_001);
  endtask

  task automatic t_dir;
    bus(20'hD0010, 0, 1); chk("R4", "write dir", buf_dir, 2'b01);
    bus(20'hD0010, 1, 0); chk("R4", "read dir", buf_dir, 2'b00);
    bus(20'hE0010, 0, 1); chk("R4", "write dir w1", buf_dir, 2'b10);
    bus(20'hC0010, 0, 1); chk("R4", "disabled dir", buf_dir, 2'b00);
  endtask

  task automatic t_result;
    bus(20'hDF000, 0, 0); chk("R2", "DF000 result", res_hit, 2'b01);
    bus(20'hDEFFF, 0, 0); chk("R2", "DEFFF program", res_hit, 2'b00);
    bus(20'hEFFFF, 0, 0); chk("R2", "EFFFF result", res_hit, 2'b10);
    bus(20'hFF000, 0, 0); chk("R2", "FF000 no window", res_hit, 2'b00);
  endtask

  task automatic t_run_halt;
    ctl_write(6'b001_011);               // run slave0
    chk("R6", "slave0 released", slv_reset_n, 2'b01);
    bus(20'hD0000, 1, 0);
    chk("R5", "running slave0 refused", buf_en, 2'b00);
    chk("R5", "slave1 in reset allowed", {buf_en[1], 1'b0}, 2'b00);
    bus(20'hE0000, 1, 0);
    chk("R5", "slave1 in reset allowed", buf_en, 2'b10);
    @(negedge clk); slv_status = 6'b000_011;
    @(negedge clk); bus(20'hD0000, 1, 0);
    chk("R5", "halted slave0 allowed", buf_en, 2'b01);
    chk("R7", "irq on halt edge", host_irq, 2'b01);
    repeat (3) @(negedge clk);
    chk("R7", "irq holds", host_irq, 2'b01);
  endtask

  task automatic t_clear;
    ctl_write(6'b001_111);               // clear slave0, keep grant/run
    chk("R8", "clear bit", host_irq, 2'b00);
    repeat (3) @(negedge clk);
    chk("R7", "held halt no retrigger", host_irq, 2'b00);
    slv_status = 6'b000_000;
    @(negedge clk); slv_status = 6'b000_011;
    @(negedge clk);
    chk("R7", "second halt edge", host_irq, 2'b01);
    ctl_write(6'b001_001);               // run 1->0, no clear
    chk("R8", "reset entry keeps irq", host_irq, 2'b01);
    chk("R6", "slave0 back in reset", slv_reset_n, 2'b00);
    ctl_write(6'b001_001);               // no change
    chk("R8", "plain write keeps irq", host_irq, 2'b01);
    ctl_write(6'b001_011);               // run 0->1 clears
    chk("R8", "release clears irq", host_irq, 2'b00);
    chk("R6", "slave0 released again", slv_reset_n, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; host_addr = '0; host_rd = 0; host_wr = 0;
    ctl_we = 0; ctl_wdata = '0; slv_status = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_decode;
    t_gate;
    t_dir;
    t_result;
    t_run_halt;
    t_clear;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule